// File: doc/BRIEF.md
# Iterative Integer Multiply Unit

This unit is the multiply engine that a 64-bit integer core hands its multiply operations to. After a one-cycle start pulse it computes the full double-width product of two register-width operands, one bit of the multiplier per cycle. It then returns either the lower or the upper half of that product as a registered result and marks completion with a one-cycle done pulse. Each operand is read as signed or unsigned according to the function code. A 32-bit word mode uses only the low halves of the operands and sign-extends the 32-bit product.

Internally the unit multiplies operand magnitudes with a radix-2 shift-and-add loop. It negates the double-width product once at the end when exactly one operand is treated as signed and negative. Two enable inputs say whether multiplication is available: one for the full multiply/divide feature and one for the multiply-only subset. With neither enable set, or with a function code the unit does not implement, the start is answered at once with done and an illegal flag, and the result register is left as it was.

Top module: `mul_iter_unit`

## Requirements
- R1: Function code 3'b000 returns bits XLEN-1..0 of the product. This low half is the same whatever the signedness of the operands.
- R2: Function code 3'b001 returns bits 2*XLEN-1..XLEN of the product with both operands read as signed two's complement.
- R3: Function code 3'b010 returns the upper half of the product with op_a_i read as signed and op_b_i read as unsigned.
- R4: Function code 3'b011 returns the upper half of the product with both operands read as unsigned.
- R5: When word_i is 1 with code 3'b000 and XLEN is 64, bits 31..0 of each operand are read as signed. Bits 31..0 of their product are returned, sign-extended to 64 bits.
- R6: When both full_en_i and mulonly_en_i are 0, a start raises done_o and illegal_o together in the next cycle, and result_o keeps its previous value. When either enable is 1, the operation is carried out.
- R7: A code with bit 2 set, or word_i set with any code other than 3'b000, is handled as illegal in the same way as R6.
- R8: A legal operation accepted at a clock edge raises done_o N+1 edges later, where N is XLEN (N is 32 in word mode). An illegal one raises done_o at the accepting edge itself. busy_o is high from the edge after acceptance until the result edge.
- R9: done_o is a single-cycle pulse. result_o changes only at an edge that raises done_o and holds its value until the next completion.
- R10: A start while busy_o is high is ignored. The running operation completes with its own operands and at its own time.
- R11: After reset, busy_o, done_o and illegal_o are 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while not busy |
| func_i | input | 3 | Function code (bit 2 must be 0) |
| word_i | input | 1 | 32-bit word mode select |
| op_a_i | input | XLEN | First operand (multiplicand) |
| op_b_i | input | XLEN | Second operand (multiplier) |
| full_en_i | input | 1 | Full multiply/divide feature enabled |
| mulonly_en_i | input | 1 | Multiply-only subset enabled |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Completion was an illegal-instruction report |
| result_o | output | XLEN | Registered result |

## Verification
A corrupted accumulator, multiplicand or multiplier register shows up only at the next completion, as a wrong result value. The most negative operand, -1 and mixed-sign pairs expose sign and negation faults in the final word. A fault in the iteration counter or the state register shows up as done_o arriving at the wrong edge, as a second done pulse, or as a start accepted while busy. The bench therefore measures the latency of every operation and checks the cycle after each done pulse.

// File: rtl/mul_iter_pkg.sv
package mul_iter_pkg;

   // low two bits of the function code
   typedef enum logic [1:0] {
      MF_LOW = 2'b00,
      MF_HSS = 2'b01,
      MF_HSU = 2'b10,
      MF_HUU = 2'b11
   } mul_fn_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_RUN   = 2'b01,
      ST_FINAL = 2'b10
   } mul_st_e;

   localparam int WORD_BITS = 32;

endpackage

// File: rtl/mul_opdecode.sv
module mul_opdecode
   import mul_iter_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit WORD_EN = 1'b1
) (
   input  logic [2:0]      func_i,
   input  logic            word_i,
   input  logic [XLEN-1:0] op_a_i,
   input  logic [XLEN-1:0] op_b_i,
   input  logic            full_en_i,
   input  logic            mulonly_en_i,
   output logic [XLEN-1:0] mag_a_o,
   output logic [XLEN-1:0] mag_b_o,
   output logic            neg_o,
   output logic            high_o,
   output logic            legal_o
);

   logic [XLEN-1:0] ext_a, ext_b;
   logic            sgn_a, sgn_b, neg_a, neg_b;
   logic            word_ok;

   generate
      if (WORD_EN) begin : g_word
         always_comb begin
            ext_a   = word_i ? {{(XLEN-WORD_BITS){op_a_i[WORD_BITS-1]}}, op_a_i[WORD_BITS-1:0]} : op_a_i;
            ext_b   = word_i ? {{(XLEN-WORD_BITS){op_b_i[WORD_BITS-1]}}, op_b_i[WORD_BITS-1:0]} : op_b_i;
            word_ok = !word_i || (func_i[1:0] == MF_LOW);
         end
      end else begin : g_noword
         always_comb begin
            ext_a   = op_a_i;
            ext_b   = op_b_i;
            word_ok = !word_i;
         end
      end
   endgenerate

   always_comb begin
      sgn_a   = word_i || (func_i[1:0] != MF_HUU);
      sgn_b   = word_i || (func_i[1:0] == MF_LOW) || (func_i[1:0] == MF_HSS);
      neg_a   = sgn_a && ext_a[XLEN-1];
      neg_b   = sgn_b && ext_b[XLEN-1];
      mag_a_o = neg_a ? (~ext_a + 1'b1) : ext_a;
      mag_b_o = neg_b ? (~ext_b + 1'b1) : ext_b;
      neg_o   = neg_a ^ neg_b;
      high_o  = !word_i && (func_i[1:0] != MF_LOW);
      legal_o = (full_en_i || mulonly_en_i) && !func_i[2] && word_ok;
   end

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
   parameter int XLEN = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [XLEN-1:0]   mag_a_i,
   input  logic [XLEN-1:0]   mag_b_i,
   output logic [2*XLEN-1:0] acc_o
);

   localparam int PW = 2 * XLEN;

   logic [PW-1:0]   acc_q, mcand_q;
   logic [XLEN-1:0] mplier_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
      end else if (load_i) begin
         acc_q    <= '0;
         mcand_q  <= {{XLEN{1'b0}}, mag_a_i};
         mplier_q <= mag_b_i;
      end else if (step_i) begin
         if (mplier_q[0]) begin
            acc_q <= acc_q + mcand_q;
         end
         mcand_q  <= {mcand_q[PW-2:0], 1'b0};
         mplier_q <= {1'b0, mplier_q[XLEN-1:1]};
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/mul_result_fmt.sv
module mul_result_fmt
   import mul_iter_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit WORD_EN = 1'b1
) (
   input  logic [2*XLEN-1:0] acc_i,
   input  logic              neg_i,
   input  logic              high_i,
   input  logic              word_i,
   output logic [XLEN-1:0]   res_o
);

   logic [2*XLEN-1:0] full;
   logic [XLEN-1:0]   half;

   always_comb begin
      full = neg_i ? (~acc_i + 1'b1) : acc_i;
      half = high_i ? full[2*XLEN-1:XLEN] : full[XLEN-1:0];
   end

   generate
      if (WORD_EN) begin : g_word
         assign res_o = word_i ? {{(XLEN-WORD_BITS){full[WORD_BITS-1]}}, full[WORD_BITS-1:0]} : half;
      end else begin : g_noword
         logic unused_word;
         assign unused_word = word_i;
         assign res_o = half;
      end
   endgenerate

endmodule

// File: rtl/mul_iter_unit.sv
module mul_iter_unit
   import mul_iter_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic [2:0]      func_i,
   input  logic            word_i,
   input  logic [XLEN-1:0] op_a_i,
   input  logic [XLEN-1:0] op_b_i,
   input  logic            full_en_i,
   input  logic            mulonly_en_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            illegal_o,
   output logic [XLEN-1:0] result_o
);

   localparam bit WORD_EN = (XLEN == 64);
   localparam int CNT_W   = $clog2(XLEN + 1);

   generate
      if (XLEN < 4 || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("mul_iter_unit: XLEN must be even and at least 4");
      end
   endgenerate

   mul_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic            neg_q, high_q, word_q;
   logic [XLEN-1:0] mag_a, mag_b;
   logic            neg_d, high_d, legal_d;
   logic [2*XLEN-1:0] acc;
   logic [XLEN-1:0] fmt_res;
   logic [CNT_W-1:0] last_cnt;
   logic            accept, load, step;

   mul_opdecode #(.XLEN(XLEN), .WORD_EN(WORD_EN)) u_dec (
      .func_i       (func_i),
      .word_i       (word_i),
      .op_a_i       (op_a_i),
      .op_b_i       (op_b_i),
      .full_en_i    (full_en_i),
      .mulonly_en_i (mulonly_en_i),
      .mag_a_o      (mag_a),
      .mag_b_o      (mag_b),
      .neg_o        (neg_d),
      .high_o       (high_d),
      .legal_o      (legal_d)
   );

   assign accept = start_i && (st_q == ST_IDLE);
   assign load   = accept && legal_d;
   assign step   = (st_q == ST_RUN);

   mul_shift_add #(.XLEN(XLEN)) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .step_i  (step),
      .mag_a_i (mag_a),
      .mag_b_i (mag_b),
      .acc_o   (acc)
   );

   mul_result_fmt #(.XLEN(XLEN), .WORD_EN(WORD_EN)) u_fmt (
      .acc_i  (acc),
      .neg_i  (neg_q),
      .high_i (high_q),
      .word_i (word_q),
      .res_o  (fmt_res)
   );

   assign last_cnt = word_q ? CNT_W'(WORD_BITS - 1) : CNT_W'(XLEN - 1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         neg_q     <= 1'b0;
         high_q    <= 1'b0;
         word_q    <= 1'b0;
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
         result_o  <= '0;
      end else begin
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  if (legal_d) begin
                     st_q   <= ST_RUN;
                     cnt_q  <= '0;
                     neg_q  <= neg_d;
                     high_q <= high_d;
                     word_q <= word_i && WORD_EN;
                  end else begin
                     done_o    <= 1'b1;
                     illegal_o <= 1'b1;
                  end
               end
            end
            ST_RUN: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == last_cnt) begin
                  st_q <= ST_FINAL;
               end
            end
            ST_FINAL: begin
               result_o <= fmt_res;
               done_o   <= 1'b1;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/mul_iter_chk.sv
module mul_iter_chk #(
   parameter int XLEN = 64
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            start_i,
   input logic            word_i,
   input logic            busy_o,
   input logic            done_o,
   input logic            illegal_o,
   input logic [XLEN-1:0] result_o
);

   logic word_seen;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_seen <= 1'b0;
      end else if (start_i && !busy_o) begin
         word_seen <= word_i;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !start_i |=> !done_o); // R9

   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o)); // R9

   AST_ILLEGAL_KEEPS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> $stable(result_o)); // R6

   AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> done_o); // R7

   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (busy_o || done_o)); // R10

   AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o); // R8

   generate
      if (XLEN == 64) begin : g_word_chk
         AST_WORD_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_o && !illegal_o && word_seen |-> (result_o[63:32] == {32{result_o[31]}})); // R5
      end
   endgenerate

endmodule

bind mul_iter_unit mul_iter_chk #(.XLEN(XLEN)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .start_i   (start_i),
   .word_i    (word_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .illegal_o (illegal_o),
   .result_o  (result_o)
);

// File: tb/mul_iter_unit_tb.sv
module mul_iter_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 64;
   localparam int WATCHDOG   = 190000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [2:0]      func = 3'b000;
   logic            word = 1'b0;
   logic [XLEN-1:0] op_a = '0;
   logic [XLEN-1:0] op_b = '0;
   logic            full_en = 1'b1;
   logic            mulonly_en = 1'b0;
   logic            busy, done, illegal;
   logic [XLEN-1:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mul_iter_unit #(.XLEN(XLEN)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .start_i      (start),
      .func_i       (func),
      .word_i       (word),
      .op_a_i       (op_a),
      .op_b_i       (op_b),
      .full_en_i    (full_en),
      .mulonly_en_i (mulonly_en),
      .busy_o       (busy),
      .done_o       (done),
      .illegal_o    (illegal),
      .result_o     (result)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [2:0] f, input logic w);
      logic [127:0] ea, eb, p;
      if (w) begin
         ea = {{96{a[31]}}, a[31:0]};
         eb = {{96{b[31]}}, b[31:0]};
         p  = ea * eb;
         return {{32{p[31]}}, p[31:0]};
      end
      ea = (f[1:0] != 2'b11) ? {{64{a[63]}}, a} : {64'b0, a};
      eb = (f[1:0] == 2'b00 || f[1:0] == 2'b01) ? {{64{b[63]}}, b} : {64'b0, b};
      p  = ea * eb;
      return (f[1:0] == 2'b00) ? p[63:0] : p[127:64];
   endfunction

   // runs one operation; lat counts edges after the accepting edge until done is seen
   task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [2:0] f,
                         input logic w, output logic [63:0] res, output int lat, output logic ill);
      @(negedge clk);
      op_a = a; op_b = b; func = f; word = w; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      res = result;
      ill = illegal;
   endtask

   task automatic legal_op(input logic [63:0] a, input logic [63:0] b, input logic [2:0] f,
                           input logic w, input string req);
      logic [63:0] res, exp;
      int lat;
      logic ill;
      run_op(a, b, f, w, res, lat, ill);
      exp = model(a, b, f, w);
      chk(res == exp && !ill, req, {64'b0, res}, {64'b0, exp});
      chk(lat == (w ? 33 : 65), "R8 latency", lat, (w ? 33 : 65));
      @(negedge clk);
      chk(!done && result == res, "R9 done pulse / hold", {63'b0, done, res}, {64'b0, res});
   endtask

   task automatic illegal_op(input logic [2:0] f, input logic w, input string req);
      logic [63:0] prev, res;
      int lat;
      logic ill;
      prev = result;
      run_op(64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, f, w, res, lat, ill);
      chk(ill && lat == 0 && res == prev, req, {ill, 31'b0, lat[31:0], res}, {1'b1, 63'b0, prev});
      @(negedge clk);
      chk(!done && !illegal && result == prev, req, {62'b0, done, illegal, result}, {64'b0, prev});
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [63:0] cv [9];
      logic [63:0] res_a;
      int lat;
      logic ill;
      cv = '{64'h0, 64'h1, 64'hffff_ffff_ffff_ffff, 64'h8000_0000_0000_0000,
             64'h7fff_ffff_ffff_ffff, 64'h2, 64'h0000_0000_ffff_ffff,
             64'hffff_ffff_8000_0000, 64'h8000_0000_0000_0001};

      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !done && !illegal && result == '0, "R11 reset",
          {61'b0, busy, done, illegal, result}, 128'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // corner sweep: every pair in every code (R1..R4)
      for (int i = 0; i < 9; i++) begin
         for (int j = 0; j < 9; j++) begin
            legal_op(cv[i], cv[j], 3'b000, 1'b0, "R1 low half");
            legal_op(cv[i], cv[j], 3'b001, 1'b0, "R2 high s*s");
            legal_op(cv[i], cv[j], 3'b010, 1'b0, "R3 high s*u");
            legal_op(cv[i], cv[j], 3'b011, 1'b0, "R4 high u*u");
            legal_op(cv[i], cv[j], 3'b000, 1'b1, "R5 word");
         end
      end

      // random operands
      for (int k = 0; k < 150; k++) begin
         logic [63:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         legal_op(ra, rb, 3'(k % 4), 1'b0, "R1-4 random");
         legal_op(ra, rb, 3'b000, 1'b1, "R5 word random");
      end

      // R6 enables: multiply-only subset alone is enough
      full_en = 1'b0; mulonly_en = 1'b1;
      legal_op(64'hffff_ffff_ffff_fffd, 64'h7, 3'b001, 1'b0, "R6 mul-only enable");
      // R6 neither enable -> illegal, result kept
      mulonly_en = 1'b0;
      illegal_op(3'b000, 1'b0, "R6 disabled");
      full_en = 1'b1;

      // R7 bad codes
      illegal_op(3'b100, 1'b0, "R7 code bit2");
      illegal_op(3'b111, 1'b0, "R7 code bit2");
      illegal_op(3'b001, 1'b1, "R7 word with high code");
      illegal_op(3'b011, 1'b1, "R7 word with high code");

      // R10 start while busy is ignored
      @(negedge clk);
      op_a = 64'h8000_0000_0000_0000; op_b = 64'hffff_ffff_ffff_ffff;
      func = 3'b001; word = 1'b0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      repeat (10) begin @(negedge clk); lat++; end
      op_a = 64'h3; op_b = 64'h5; func = 3'b000; word = 1'b1; start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      chk(busy, "R10 still busy", {127'b0, busy}, 128'b1);
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      res_a = result; ill = illegal;
      chk(res_a == model(64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 3'b001, 1'b0) && !ill,
          "R10 result of first op", {64'b0, res_a},
          {64'b0, model(64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 3'b001, 1'b0)});
      chk(lat == 65, "R10 timing of first op", lat, 65);
      @(negedge clk);
      chk(!done && !busy, "R10 no second run", {126'b0, done, busy}, 128'b0);
      repeat (5) @(negedge clk);
      chk(result == res_a, "R9 result held while idle", {64'b0, result}, {64'b0, res_a});

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule